// File: doc/BRIEF.md
# Audio Coprocessor Bus Decoder

This block sits between the bus of a small audio coprocessor and its local resources. Every access arrives as a 16-bit address with a one-cycle read or write strobe. The block steers the access to one of three places. Most addresses go to local RAM. A 64-byte boot ROM overlays the top of the map, and only for reads. A 16-byte register page sits at 0x00F0–0x00FF. The page holds the configuration bits that steer the decode itself: overlay enable, register-write lock and RAM write enable. It also holds two scratch bytes, and an address/data pair that gives indirect access to a 128-entry sound-register file. Mailbox and timer slots in the page are not held here. The block passes them out as strobes with a slot index, and returns the neighbour's read data.

The coprocessor core spaces its strobes into 24-clock bus cycles. Each strobe is one clock wide. Register-page writes have no register effect while the lock bit is set. Even so, every write, register writes included, is copied into RAM while RAM writing is enabled. The RAM is a behavioural array indexed by the low `RAM_AW` address bits, so it is mirrored across the map.

Top module: `apu_addr_decode`

## Requirements
- R1: After reset, the scratch bytes (0xF8, 0xF9) and the sound-address byte (0xF2) read 0x00, the ROM overlay is on, RAM writing is enabled and the register lock is off.
- R2: A read in 0xFFC0–0xFFFF returns ROM byte i = addr[5:0], valued ({i,2'b01} ^ 0x3C), when the overlay is on. It returns RAM when the overlay is off. Bit 7 of a write to 0xF1 sets the overlay state.
- R3: A write in 0xFFC0–0xFFFF lands in RAM whether or not the overlay is on.
- R4: Reads of 0xF0, 0xF1, 0xFA, 0xFB and 0xFC return 0x00.
- R5: A write to 0xF0 takes effect only while pflag_i is low. Data bit 2 sets the register lock and bit 1 sets RAM writing.
- R6: While the lock is set, writes to 0x00F0–0x00FF change no register and raise no mbox_wr_o, tmr_wr_o or ctl_wr_o. Writes elsewhere are unaffected.
- R7: Every write, including one to the register page, is stored into RAM at index addr[RAM_AW-1:0] when RAM writing is enabled. For a write to 0xF0 that takes effect, the newly written bit 1 decides.
- R8: 0xF2 is a read/write sound-register address. 0xF3 reads the sound register at (address & 0x7F). A write through 0xF3 is dropped while address bit 7 is set.
- R9: 0xF8 and 0xF9 are independent 8-bit read/write scratch registers.
- R10: Accesses to 0xF4–0xF7 raise mbox_rd_o or mbox_wr_o in the strobe cycle, with reg_idx_o = addr[1:0]. A mailbox read returns mbox_rdata_i. Reads are never blocked by the lock.
- R11: Writes to 0xFA–0xFC raise tmr_wr_o, and reads of 0xFD–0xFF raise tmr_rd_o, with reg_idx_o = 0, 1, 2 in address order. A timer read returns tmr_rdata_i. A write to 0xF1 pulses ctl_wr_o.
- R12: rdata_o is loaded on the clock edge that samples rd_i and holds between reads. At most one of the five neighbour strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Bus write data |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| pflag_i | input | 1 | Processor P flag; a high level blocks 0xF0 writes |
| rdata_o | output | 8 | Registered read data |
| mbox_rdata_i | input | 8 | Read data from the mailbox block |
| tmr_rdata_i | input | 8 | Read data from the timer block |
| reg_idx_o | output | 2 | Slot index for mailbox or timer strobes |
| mbox_rd_o | output | 1 | Mailbox read strobe |
| mbox_wr_o | output | 1 | Mailbox write strobe |
| tmr_rd_o | output | 1 | Timer counter read strobe |
| tmr_wr_o | output | 1 | Timer target write strobe |
| ctl_wr_o | output | 1 | Control (0xF1) write strobe for timer enables and mailbox clears |

## Verification
The hardest behaviour to see from the ports is the RAM copy of register-page writes. Reads of 0x00F0–0x00FF always decode to registers, so the RAM bytes underneath them cannot be read at those addresses. The stimulus reaches them through the RAM mirror at 0x04F0–0x04FF. It uses this path to confirm three things: that scratch and 0xF0 writes are copied, that a 0xF0 write clearing bit 1 is itself not stored, and that one setting bit 1 is stored. The lock is tested last, because once set it cannot be undone without reset.

// File: rtl/apu_dec_pkg.sv
package apu_dec_pkg;
  localparam logic [11:0] PAGE_HI  = 12'h00F;
  localparam logic [3:0]  OFS_TEST = 4'h0;
  localparam logic [3:0]  OFS_CTRL = 4'h1;
  localparam logic [3:0]  OFS_SADR = 4'h2;
  localparam logic [3:0]  OFS_SDAT = 4'h3;
  localparam logic [3:0]  OFS_SCR0 = 4'h8;
  localparam logic [3:0]  OFS_SCR1 = 4'h9;

  localparam logic [7:0] RST_SCRATCH = 8'h00;

  typedef enum logic [1:0] {RG_RAM, RG_ROM, RG_PAGE} region_e;

  function automatic logic [7:0] boot_byte(input logic [5:0] idx);
    return {idx, 2'b01} ^ 8'h3C;
  endfunction
endpackage

// File: rtl/apu_ram.sv
module apu_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/apu_boot_rom.sv
module apu_boot_rom
  import apu_dec_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] rom [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    localparam logic [AW-1:0] IDX = AW'(gi);
    assign rom[gi] = boot_byte(6'(IDX));
  end

  assign rdata_o = rom[addr_i];
endmodule

// File: rtl/apu_snd_file.sv
module apu_snd_file #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] regs_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[addr_i];
endmodule

// File: rtl/apu_addr_decode.sv
module apu_addr_decode
  import apu_dec_pkg::*;
#(
  parameter int RAM_AW    = 10,
  parameter int ROM_AW    = 6,
  parameter int SND_DEPTH = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic        pflag_i,
  output logic [7:0]  rdata_o,
  input  logic [7:0]  mbox_rdata_i,
  input  logic [7:0]  tmr_rdata_i,
  output logic [1:0]  reg_idx_o,
  output logic        mbox_rd_o,
  output logic        mbox_wr_o,
  output logic        tmr_rd_o,
  output logic        tmr_wr_o,
  output logic        ctl_wr_o
);
  localparam int SND_AW = $clog2(SND_DEPTH);

  // control state
  logic       rom_en_q, ram_wen_q, lock_q;
  logic [7:0] scr0_q, scr1_q, snd_addr_q, rdata_q;

  // decode
  logic       page_hit, rom_hit, mbox_hit, tgt_hit, tout_hit;
  logic [3:0] ofs;
  region_e    region;

  assign ofs      = addr_i[3:0];
  assign page_hit = (addr_i[15:4] == PAGE_HI);
  assign rom_hit  = &addr_i[15:ROM_AW];
  assign mbox_hit = page_hit && (ofs[3:2] == 2'b01);
  assign tgt_hit  = page_hit && (ofs inside {4'hA, 4'hB, 4'hC});
  assign tout_hit = page_hit && (ofs inside {4'hD, 4'hE, 4'hF});

  always_comb begin
    if (page_hit)                region = RG_PAGE;
    else if (rom_hit && rom_en_q) region = RG_ROM;
    else                          region = RG_RAM;
  end

  // write qualification
  logic wr_reg, test_acc, saddr_we, sdata_we, ram_we;

  assign wr_reg   = wr_i && page_hit && !lock_q;
  assign test_acc = wr_reg && (ofs == OFS_TEST) && !pflag_i;
  assign saddr_we = wr_reg && (ofs == OFS_SADR);
  assign sdata_we = wr_reg && (ofs == OFS_SDAT) && !snd_addr_q[7];
  // an accepted TEST write decides its own write-through
  assign ram_we   = wr_i && (test_acc ? wdata_i[1] : ram_wen_q);

  assign ctl_wr_o  = wr_reg && (ofs == OFS_CTRL);
  assign mbox_wr_o = wr_reg && mbox_hit;
  assign mbox_rd_o = rd_i && mbox_hit;
  assign tmr_wr_o  = wr_reg && tgt_hit;
  assign tmr_rd_o  = rd_i && tout_hit;

  always_comb begin
    if (tout_hit)     reg_idx_o = ofs[1:0] - 2'd1;
    else if (tgt_hit) reg_idx_o = ofs[1:0] - 2'd2;
    else              reg_idx_o = ofs[1:0];
  end

  // storage
  logic [7:0] ram_rdata, rom_rdata, snd_rdata;

  apu_ram #(.AW(RAM_AW), .DW(8)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (addr_i[RAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  apu_boot_rom #(.AW(ROM_AW)) u_rom (
    .addr_i  (addr_i[ROM_AW-1:0]),
    .rdata_o (rom_rdata)
  );

  apu_snd_file #(.DEPTH(SND_DEPTH), .DW(8)) u_snd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sdata_we),
    .addr_i  (snd_addr_q[SND_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (snd_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_en_q   <= 1'b1;
      ram_wen_q  <= 1'b1;
      lock_q     <= 1'b0;
      scr0_q     <= RST_SCRATCH;
      scr1_q     <= RST_SCRATCH;
      snd_addr_q <= '0;
    end else begin
      if (test_acc) begin
        lock_q    <= wdata_i[2];
        ram_wen_q <= wdata_i[1];
      end
      if (ctl_wr_o) rom_en_q <= wdata_i[7];
      if (saddr_we) snd_addr_q <= wdata_i;
      if (wr_reg && ofs == OFS_SCR0) scr0_q <= wdata_i;
      if (wr_reg && ofs == OFS_SCR1) scr1_q <= wdata_i;
    end
  end

  // read path
  logic [7:0] page_rd, rd_mux;

  always_comb begin
    unique case (ofs)
      OFS_SADR:                   page_rd = snd_addr_q;
      OFS_SDAT:                   page_rd = snd_rdata;
      4'h4, 4'h5, 4'h6, 4'h7:     page_rd = mbox_rdata_i;
      OFS_SCR0:                   page_rd = scr0_q;
      OFS_SCR1:                   page_rd = scr1_q;
      4'hD, 4'hE, 4'hF:           page_rd = tmr_rdata_i;
      default:                    page_rd = 8'h00;
    endcase
  end

  always_comb begin
    unique case (region)
      RG_PAGE: rd_mux = page_rd;
      RG_ROM:  rd_mux = rom_rdata;
      default: rd_mux = ram_rdata;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // assertions
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i)); // R12
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mbox_rd_o, mbox_wr_o, tmr_rd_o, tmr_wr_o, ctl_wr_o})); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R12
  AST_OVERLAY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && rom_hit && rom_en_q |=> rdata_o == $past(rom_rdata)); // R2
  AST_PFLAG_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && page_hit && ofs == OFS_TEST && pflag_i |=> $stable(lock_q) && $stable(ram_wen_q)); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && wr_i && page_hit |=> $stable(scr0_q) && $stable(scr1_q) && $stable(snd_addr_q) && $stable(rom_en_q)); // R6
  AST_MIRROR_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && page_hit && ofs == OFS_SDAT && snd_addr_q[7] |=> $stable(snd_rdata)); // R8
endmodule

// File: tb/apu_addr_decode_bench.sv
module apu_addr_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0, pflag = 1'b0;
  logic [7:0]  rdata, mbox_rdata, tmr_rdata;
  logic [1:0]  reg_idx;
  logic        mbox_rd, mbox_wr, tmr_rd, tmr_wr, ctl_wr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // neighbour models: data depends on slot index
  assign mbox_rdata = 8'h90 + {6'b0, reg_idx};
  assign tmr_rdata  = 8'h40 + {6'b0, reg_idx};

  apu_addr_decode u_apu_addr_decode (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .pflag_i(pflag), .rdata_o(rdata),
    .mbox_rdata_i(mbox_rdata), .tmr_rdata_i(tmr_rdata), .reg_idx_o(reg_idx),
    .mbox_rd_o(mbox_rd), .mbox_wr_o(mbox_wr), .tmr_rd_o(tmr_rd),
    .tmr_wr_o(tmr_wr), .ctl_wr_o(ctl_wr)
  );

  // {is_wr, pflag, addr, data_or_expected, req}
  localparam int NV = 55;
  localparam logic [29:0] VECS [NV] = '{
    {1'b0,1'b0,16'h00F8,8'h00,4'd1},  // R1 scratch reset
    {1'b0,1'b0,16'h00F2,8'h00,4'd1},  // R1 sound address reset
    {1'b0,1'b0,16'hFFC5,8'h29,4'd1},  // R1 overlay on after reset
    {1'b1,1'b0,16'h0123,8'h5A,4'd7},
    {1'b0,1'b0,16'h0123,8'h5A,4'd7},  // R7 plain RAM
    {1'b1,1'b0,16'hFFC5,8'h77,4'd3},
    {1'b0,1'b0,16'hFFC5,8'h29,4'd2},  // R2 ROM still shadows
    {1'b1,1'b0,16'h00F1,8'h00,4'd2},
    {1'b0,1'b0,16'hFFC5,8'h77,4'd3},  // R3 write reached RAM
    {1'b1,1'b0,16'h00F1,8'h80,4'd2},
    {1'b0,1'b0,16'hFFC0,8'h3D,4'd2},  // R2 first ROM byte
    {1'b0,1'b0,16'hFFFF,8'hC1,4'd2},  // R2 last ROM byte
    {1'b0,1'b0,16'h00F0,8'h00,4'd4},  // R4
    {1'b0,1'b0,16'h00F1,8'h00,4'd4},  // R4
    {1'b0,1'b0,16'h00FA,8'h00,4'd4},  // R4
    {1'b0,1'b0,16'h00FB,8'h00,4'd4},  // R4
    {1'b0,1'b0,16'h00FC,8'h00,4'd4},  // R4
    {1'b1,1'b0,16'h00F8,8'hC3,4'd9},
    {1'b1,1'b0,16'h00F9,8'h3C,4'd9},
    {1'b0,1'b0,16'h00F8,8'hC3,4'd9},  // R9
    {1'b0,1'b0,16'h00F9,8'h3C,4'd9},  // R9
    {1'b0,1'b0,16'h04F9,8'h3C,4'd7},  // R7 page write copied, seen via mirror
    {1'b1,1'b0,16'h00F2,8'h05,4'd8},
    {1'b1,1'b0,16'h00F3,8'h66,4'd8},
    {1'b0,1'b0,16'h00F2,8'h05,4'd8},  // R8
    {1'b0,1'b0,16'h00F3,8'h66,4'd8},  // R8
    {1'b1,1'b0,16'h00F2,8'h85,4'd8},
    {1'b0,1'b0,16'h00F3,8'h66,4'd8},  // R8 upper half mirrors
    {1'b1,1'b0,16'h00F3,8'h11,4'd8},
    {1'b1,1'b0,16'h00F2,8'h05,4'd8},
    {1'b0,1'b0,16'h00F3,8'h66,4'd8},  // R8 mirror write dropped
    {1'b0,1'b0,16'h00F4,8'h90,4'd10}, // R10
    {1'b0,1'b0,16'h00F7,8'h93,4'd10}, // R10
    {1'b0,1'b0,16'h00FD,8'h40,4'd11}, // R11
    {1'b0,1'b0,16'h00FF,8'h42,4'd11}, // R11
    {1'b1,1'b1,16'h00F0,8'h04,4'd5},  // blocked by pflag
    {1'b1,1'b0,16'h00F8,8'h11,4'd5},
    {1'b0,1'b0,16'h00F8,8'h11,4'd5},  // R5 lock not set
    {1'b1,1'b0,16'h04F0,8'hAB,4'd7},
    {1'b1,1'b0,16'h0200,8'h22,4'd5},
    {1'b1,1'b0,16'h00F0,8'h00,4'd5},  // RAM writing off
    {1'b0,1'b0,16'h04F0,8'hAB,4'd7},  // R7 clearing write not stored
    {1'b1,1'b0,16'h0200,8'h55,4'd5},
    {1'b0,1'b0,16'h0200,8'h22,4'd5},  // R5 RAM write blocked
    {1'b1,1'b0,16'h00F0,8'h02,4'd5},
    {1'b0,1'b0,16'h04F0,8'h02,4'd7},  // R7 enabling write stored
    {1'b1,1'b0,16'h00F0,8'h06,4'd6},  // lock on
    {1'b1,1'b0,16'h00F8,8'h99,4'd6},
    {1'b0,1'b0,16'h00F8,8'h11,4'd6},  // R6 scratch unchanged
    {1'b0,1'b0,16'h04F8,8'h99,4'd7},  // R7 still copied to RAM
    {1'b1,1'b0,16'h00F1,8'h00,4'd6},
    {1'b0,1'b0,16'hFFC5,8'h29,4'd6},  // R6 overlay unchanged
    {1'b1,1'b0,16'h00F0,8'h00,4'd6},
    {1'b1,1'b0,16'h0300,8'h7E,4'd6},
    {1'b0,1'b0,16'h0300,8'h7E,4'd6}   // R6 TEST write ignored, RAM writable
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic p);
    @(negedge clk);
    addr = a; wdata = d; pflag = p; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; pflag = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  // strobes {mbox_rd, mbox_wr, tmr_rd, tmr_wr, ctl_wr, idx}
  task automatic probe(input string req, input logic is_wr, input logic [15:0] a,
                       input logic [6:0] exp);
    @(negedge clk);
    addr = a; wdata = 8'h00; wr = is_wr; rd = !is_wr;
    #1;
    check(req, {1'b0, mbox_rd, mbox_wr, tmr_rd, tmr_wr, ctl_wr, reg_idx},
          {1'b0, exp});
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] got;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][29]) begin
        do_write(VECS[i][27:12], VECS[i][11:4], VECS[i][28]);
      end else begin
        do_read(VECS[i][27:12], got);
        check($sformatf("R%0d vec%0d", VECS[i][3:0], i), got, VECS[i][11:4]);
      end
    end

    // lock still on: writes to page raise no strobes, reads still do
    probe("R6 mbox write under lock", 1'b1, 16'h00F5, 7'b00000_01);
    probe("R6 ctl write under lock",  1'b1, 16'h00F1, 7'b00000_01);
    probe("R10 mbox read under lock", 1'b0, 16'h00F5, 7'b10000_01);

    do_reset();
    do_read(16'h00F9, got); check("R1 scratch after reset", got, 8'h00);
    do_read(16'hFFC1, got); check("R1 overlay after reset", got, 8'h39);
    probe("R10 mbox write slot1",  1'b1, 16'h00F5, 7'b01000_01);
    probe("R10 mbox write slot3",  1'b1, 16'h00F7, 7'b01000_11);
    probe("R11 target write slot1", 1'b1, 16'h00FB, 7'b00010_01);
    probe("R11 target write slot2", 1'b1, 16'h00FC, 7'b00010_10);
    probe("R11 counter read slot1", 1'b0, 16'h00FE, 7'b00100_01);
    probe("R11 ctl write",          1'b1, 16'h00F1, 7'b00001_01);
    probe("R12 no strobe for RAM",  1'b1, 16'h0145, 7'b00000_01);

    // R12 hold between reads
    do_write(16'h00F8, 8'hAA, 1'b0);
    do_read(16'h00F8, got); check("R12 read", got, 8'hAA);
    do_write(16'h00F8, 8'hBB, 1'b0);
    repeat (3) @(negedge clk);
    check("R12 hold", rdata, 8'hAA);
    do_read(16'h00F8, got); check("R12 reload", got, 8'hBB);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule